// File: doc/BRIEF.md
# Thread Block Distributor

The block takes kernels from the head of a kernel queue and hands out their thread blocks to a row of multiprocessors, one block per cycle at most. A kernel descriptor gives its queue index, its block count and the threads, registers and shared-memory bytes that each block needs. Once a kernel is taken into the current-kernel registers, its blocks are issued with ascending IDs starting at zero.

The target multiprocessor is picked by a round-robin pointer. A block goes out only if that target has room for it. Each multiprocessor keeps a table of resident-block slots, and each slot records the kernel index, the block ID and the resources the block holds. When a multiprocessor reports that a block has finished, the slot and its resources are returned. The kernel's finished-block count also goes up by one. When the count reaches the kernel's block total, a completion pulse is raised.

When the last block of the current kernel has been issued, the next queued kernel is taken at once. So blocks of several kernels can be resident on one multiprocessor at the same time.

Top module: `blk_issue_top`

## Requirements
- R1: After reset nothing is issued, the queue is not popped, no completion is pulsed, and every multiprocessor has all of its slots, threads, registers and shared memory free.
- R2: The queue head is accepted, with `kq_pop` high in that same cycle, only when no kernel is current. The current kernel issues its blocks from the next cycle on, with IDs 0, 1, 2 and so on in order.
- R3: At most one block is issued per cycle. The target is multiprocessor `rr`, where `rr` starts at 0 and steps 0, 1, …, MP_N-1 and back to 0 in every cycle in which a kernel is current, whether or not a block goes out. It holds in cycles with no current kernel.
- R4: A block is issued only if the target has enough free threads, free registers and free shared memory, and at least one empty slot. Otherwise nothing is issued that cycle.
- R5: Each multiprocessor holds at most NSLOT (16) blocks and MAX_THR (2048) threads. The issued block takes the lowest-numbered empty slot, which is reported on `iss_slot`.
- R6: A finish notification on `fin_mp`/`fin_slot` frees that slot and its resources at the next clock edge. They cannot be used for an issue in the cycle of the notification.
- R7: In the cycle after the last block of a kernel is issued, the next queued kernel can be accepted. Its blocks may share a multiprocessor with blocks of the earlier kernel.
- R8: `kdone_valid` pulses for one cycle, with `kdone_kidx`, in the cycle after the notification that brings the kernel's finished-block count up to its block total.
- R9: A queue head whose index still belongs to a kernel with unfinished blocks is not accepted. It is accepted in the cycle in which that kernel's completion is pulsed.
- R10: A finish notification for an empty slot frees nothing and updates no kernel count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kq_valid | input | 1 | Kernel queue head is valid |
| kq_kidx | input | KIDX_W | Kernel queue index of the head |
| kq_nblk | input | BLK_W | Number of blocks in the kernel (at least 1) |
| kq_thr | input | THR_W | Threads per block |
| kq_reg | input | REG_W | Registers per block |
| kq_smem | input | SMEM_W | Shared-memory bytes per block |
| kq_pop | output | 1 | Head accepted this cycle |
| iss_valid | output | 1 | A block is issued this cycle |
| iss_mp | output | MP_W | Target multiprocessor |
| iss_slot | output | SLOT_W | Slot given to the block |
| iss_kidx | output | KIDX_W | Kernel index of the issued block |
| iss_blk | output | BLK_W | Block ID of the issued block |
| fin_valid | input | 1 | A block finished |
| fin_mp | input | MP_W | Multiprocessor reporting the finish |
| fin_slot | input | SLOT_W | Slot of the finished block |
| kdone_valid | output | 1 | A kernel completed |
| kdone_kidx | output | KIDX_W | Index of the completed kernel |

## Verification
The assertions are checked on every cycle. They cover the stepping of the round-robin pointer, that a grant only ever reaches a multiprocessor reporting room, the thread and shared-memory capacity bounds, that a freed slot is empty after the edge, and that the head is never taken while a kernel is current or while its index is busy. Some behaviour only the directed scenarios can show: the exact order of targets and slots, stalling under each kind of resource limit, the one-cycle delay before freed resources can be used, kernels mixing on a multiprocessor, completion order, and ignored notifications for empty slots.

// File: rtl/blk_issue_pkg.sv
package blk_issue_pkg;

  // Resource check: every demand within what is free, and a slot is open.
  function automatic logic fits(input int unsigned free_thr, input int unsigned need_thr,
                                input int unsigned free_reg, input int unsigned need_reg,
                                input int unsigned free_sm,  input int unsigned need_sm,
                                input logic slot_open);
    return slot_open && (need_thr <= free_thr) && (need_reg <= free_reg) && (need_sm <= free_sm);
  endfunction

  // Next round-robin position among n targets.
  function automatic int unsigned rr_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/blk_issue_ctrl.sv
module blk_issue_ctrl
  import blk_issue_pkg::*;
#(
  parameter int MP_N   = 4,
  parameter int KERN_N = 4,
  parameter int BLK_W  = 16,
  parameter int THR_W  = 12,
  parameter int REG_W  = 17,
  parameter int SMEM_W = 16,
  localparam int MP_W   = (MP_N > 1) ? $clog2(MP_N) : 1,
  localparam int KIDX_W = (KERN_N > 1) ? $clog2(KERN_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kq_valid,
  input  logic [KIDX_W-1:0] kq_kidx,
  input  logic [BLK_W-1:0]  kq_nblk,
  input  logic [THR_W-1:0]  kq_thr,
  input  logic [REG_W-1:0]  kq_reg,
  input  logic [SMEM_W-1:0] kq_smem,
  input  logic [KERN_N-1:0] busy,
  input  logic [MP_N-1:0]   fit,
  output logic              kq_pop,
  output logic              iss_valid,
  output logic [MP_W-1:0]   rr,
  output logic [KIDX_W-1:0] cur_kidx,
  output logic [BLK_W-1:0]  next_blk,
  output logic [THR_W-1:0]  cur_thr,
  output logic [REG_W-1:0]  cur_reg,
  output logic [SMEM_W-1:0] cur_smem
);

  logic             cur_valid;
  logic [BLK_W-1:0] cur_nblk;
  logic             last_blk;
  logic             attempt;

  assign attempt   = cur_valid;
  assign kq_pop    = kq_valid && !cur_valid && !busy[kq_kidx];
  assign iss_valid = cur_valid && fit[rr];
  assign last_blk  = (next_blk == cur_nblk - BLK_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
      cur_kidx  <= '0;
      cur_nblk  <= '0;
      next_blk  <= '0;
      cur_thr   <= '0;
      cur_reg   <= '0;
      cur_smem  <= '0;
      rr        <= '0;
    end else begin
      if (attempt) rr <= MP_W'(rr_next(32'(rr), MP_N));
      if (kq_pop) begin
        cur_valid <= 1'b1;
        cur_kidx  <= kq_kidx;
        cur_nblk  <= kq_nblk;
        next_blk  <= '0;
        cur_thr   <= kq_thr;
        cur_reg   <= kq_reg;
        cur_smem  <= kq_smem;
      end else if (iss_valid) begin
        next_blk <= next_blk + BLK_W'(1);
        if (last_blk) cur_valid <= 1'b0;
      end
    end
  end

  assert_rr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    attempt |=> rr == MP_W'(rr_next(32'($past(rr)), MP_N)));
  assert_rr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !attempt |=> $stable(rr));
  assert_pop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    kq_pop |-> !iss_valid);

endmodule

// File: rtl/blk_mp_res.sv
module blk_mp_res
  import blk_issue_pkg::*;
#(
  parameter int NSLOT    = 16,
  parameter int MAX_THR  = 2048,
  parameter int MAX_REG  = 65536,
  parameter int MAX_SMEM = 49152,
  parameter int KIDX_W   = 2,
  parameter int BLK_W    = 16,
  localparam int SLOT_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int THR_W   = $clog2(MAX_THR + 1),
  localparam int REG_W   = $clog2(MAX_REG + 1),
  localparam int SMEM_W  = $clog2(MAX_SMEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  need_thr,
  input  logic [REG_W-1:0]  need_reg,
  input  logic [SMEM_W-1:0] need_smem,
  input  logic              alloc_en,
  input  logic [KIDX_W-1:0] alloc_kidx,
  input  logic [BLK_W-1:0]  alloc_blk,
  input  logic              rel_en,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              fit,
  output logic [SLOT_W-1:0] pick_slot,
  output logic              rel_hit,
  output logic [KIDX_W-1:0] rel_kidx,
  output logic [BLK_W-1:0]  rel_blk
);

  logic [NSLOT-1:0]  vld;
  logic [KIDX_W-1:0] s_kidx [NSLOT];
  logic [BLK_W-1:0]  s_blk  [NSLOT];
  logic [THR_W-1:0]  s_thr  [NSLOT];
  logic [REG_W-1:0]  s_reg  [NSLOT];
  logic [SMEM_W-1:0] s_smem [NSLOT];

  logic [THR_W-1:0]  free_thr,  take_thr,  ret_thr;
  logic [REG_W-1:0]  free_reg,  take_reg,  ret_reg;
  logic [SMEM_W-1:0] free_smem, take_smem, ret_smem;
  logic              slot_open;

  always_comb begin
    pick_slot = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!vld[i]) pick_slot = SLOT_W'(i);
    end
  end

  assign slot_open = ~&vld;
  assign fit = fits(32'(free_thr), 32'(need_thr), 32'(free_reg), 32'(need_reg),
                    32'(free_smem), 32'(need_smem), slot_open);

  assign rel_hit  = rel_en && vld[rel_slot];
  assign rel_kidx = s_kidx[rel_slot];
  assign rel_blk  = s_blk[rel_slot];

  assign take_thr  = alloc_en ? need_thr  : '0;
  assign take_reg  = alloc_en ? need_reg  : '0;
  assign take_smem = alloc_en ? need_smem : '0;
  assign ret_thr   = rel_hit ? s_thr[rel_slot]  : '0;
  assign ret_reg   = rel_hit ? s_reg[rel_slot]  : '0;
  assign ret_smem  = rel_hit ? s_smem[rel_slot] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      free_thr  <= THR_W'(MAX_THR);
      free_reg  <= REG_W'(MAX_REG);
      free_smem <= SMEM_W'(MAX_SMEM);
      for (int i = 0; i < NSLOT; i++) begin
        s_kidx[i] <= '0;
        s_blk[i]  <= '0;
        s_thr[i]  <= '0;
        s_reg[i]  <= '0;
        s_smem[i] <= '0;
      end
    end else begin
      free_thr  <= free_thr  - take_thr  + ret_thr;
      free_reg  <= free_reg  - take_reg  + ret_reg;
      free_smem <= free_smem - take_smem + ret_smem;
      if (rel_hit) vld[rel_slot] <= 1'b0;
      if (alloc_en) begin
        vld[pick_slot]    <= 1'b1;
        s_kidx[pick_slot] <= alloc_kidx;
        s_blk[pick_slot]  <= alloc_blk;
        s_thr[pick_slot]  <= need_thr;
        s_reg[pick_slot]  <= need_reg;
        s_smem[pick_slot] <= need_smem;
      end
    end
  end

  assert_grant_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> fit);
  assert_thr_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    free_thr <= THR_W'(MAX_THR));
  assert_smem_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    free_smem <= SMEM_W'(MAX_SMEM));
  assert_release_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit |=> !vld[$past(rel_slot)]);
  assert_empty_rel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !vld[rel_slot] && !alloc_en) |=> $stable(free_thr) && $stable(vld));

endmodule

// File: rtl/blk_kern_tbl.sv
module blk_kern_tbl #(
  parameter int KERN_N  = 4,
  parameter int BLK_W   = 16,
  localparam int KIDX_W = (KERN_N > 1) ? $clog2(KERN_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [KIDX_W-1:0] load_kidx,
  input  logic [BLK_W-1:0]  load_nblk,
  input  logic              fin_hit,
  input  logic [KIDX_W-1:0] fin_kidx,
  input  logic [BLK_W-1:0]  fin_blk,
  output logic [KERN_N-1:0] busy,
  output logic              kdone_valid,
  output logic [KIDX_W-1:0] kdone_kidx
);

  logic [BLK_W-1:0] tot [KERN_N];
  logic [BLK_W-1:0] cnt [KERN_N];
  logic             fin_last;

  assign fin_last = (cnt[fin_kidx] + BLK_W'(1) == tot[fin_kidx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= '0;
      kdone_valid <= 1'b0;
      kdone_kidx  <= '0;
      for (int k = 0; k < KERN_N; k++) begin
        tot[k] <= '0;
        cnt[k] <= '0;
      end
    end else begin
      kdone_valid <= 1'b0;
      if (load) begin
        busy[load_kidx] <= 1'b1;
        tot[load_kidx]  <= load_nblk;
        cnt[load_kidx]  <= '0;
      end
      if (fin_hit) begin
        if (fin_last) begin
          busy[fin_kidx] <= 1'b0;
          kdone_valid    <= 1'b1;
          kdone_kidx     <= fin_kidx;
        end else begin
          cnt[fin_kidx] <= cnt[fin_kidx] + BLK_W'(1);
        end
      end
    end
  end

  assert_load_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy[load_kidx]);
  assert_fin_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_hit |-> busy[fin_kidx] && (fin_blk < tot[fin_kidx]));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kdone_valid |=> !kdone_valid || $past(fin_hit));

  generate
    for (genvar k = 0; k < KERN_N; k++) begin : g_cnt_chk
      assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy[k] |-> cnt[k] < tot[k]);
    end
  endgenerate

endmodule

// File: rtl/blk_issue_top.sv
module blk_issue_top #(
  parameter int MP_N     = 4,
  parameter int NSLOT    = 16,
  parameter int MAX_THR  = 2048,
  parameter int MAX_REG  = 65536,
  parameter int MAX_SMEM = 49152,
  parameter int KERN_N   = 4,
  parameter int BLK_W    = 16,
  localparam int MP_W    = (MP_N > 1) ? $clog2(MP_N) : 1,
  localparam int SLOT_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int KIDX_W  = (KERN_N > 1) ? $clog2(KERN_N) : 1,
  localparam int THR_W   = $clog2(MAX_THR + 1),
  localparam int REG_W   = $clog2(MAX_REG + 1),
  localparam int SMEM_W  = $clog2(MAX_SMEM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kq_valid,
  input  logic [KIDX_W-1:0] kq_kidx,
  input  logic [BLK_W-1:0]  kq_nblk,
  input  logic [THR_W-1:0]  kq_thr,
  input  logic [REG_W-1:0]  kq_reg,
  input  logic [SMEM_W-1:0] kq_smem,
  output logic              kq_pop,
  output logic              iss_valid,
  output logic [MP_W-1:0]   iss_mp,
  output logic [SLOT_W-1:0] iss_slot,
  output logic [KIDX_W-1:0] iss_kidx,
  output logic [BLK_W-1:0]  iss_blk,
  input  logic              fin_valid,
  input  logic [MP_W-1:0]   fin_mp,
  input  logic [SLOT_W-1:0] fin_slot,
  output logic              kdone_valid,
  output logic [KIDX_W-1:0] kdone_kidx
);

  logic [MP_N-1:0]              fit;
  logic [MP_N-1:0]              rel_hit;
  logic [MP_N-1:0][SLOT_W-1:0]  pick_slot;
  logic [MP_N-1:0][KIDX_W-1:0]  rel_kidx;
  logic [MP_N-1:0][BLK_W-1:0]   rel_blk;
  logic [KERN_N-1:0]            busy;
  logic [MP_W-1:0]              rr;
  logic [THR_W-1:0]             cur_thr;
  logic [REG_W-1:0]             cur_reg;
  logic [SMEM_W-1:0]            cur_smem;
  logic                         fin_hit;

  blk_issue_ctrl #(
    .MP_N(MP_N), .KERN_N(KERN_N), .BLK_W(BLK_W),
    .THR_W(THR_W), .REG_W(REG_W), .SMEM_W(SMEM_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .kq_valid(kq_valid), .kq_kidx(kq_kidx), .kq_nblk(kq_nblk),
    .kq_thr(kq_thr), .kq_reg(kq_reg), .kq_smem(kq_smem),
    .busy(busy), .fit(fit),
    .kq_pop(kq_pop), .iss_valid(iss_valid), .rr(rr),
    .cur_kidx(iss_kidx), .next_blk(iss_blk),
    .cur_thr(cur_thr), .cur_reg(cur_reg), .cur_smem(cur_smem)
  );

  generate
    for (genvar m = 0; m < MP_N; m++) begin : g_mp
      blk_mp_res #(
        .NSLOT(NSLOT), .MAX_THR(MAX_THR), .MAX_REG(MAX_REG), .MAX_SMEM(MAX_SMEM),
        .KIDX_W(KIDX_W), .BLK_W(BLK_W)
      ) u_mp (
        .clk(clk), .rst_n(rst_n),
        .need_thr(cur_thr), .need_reg(cur_reg), .need_smem(cur_smem),
        .alloc_en(iss_valid && (rr == MP_W'(m))),
        .alloc_kidx(iss_kidx), .alloc_blk(iss_blk),
        .rel_en(fin_valid && (fin_mp == MP_W'(m))),
        .rel_slot(fin_slot),
        .fit(fit[m]), .pick_slot(pick_slot[m]),
        .rel_hit(rel_hit[m]), .rel_kidx(rel_kidx[m]), .rel_blk(rel_blk[m])
      );
    end
  endgenerate

  assign iss_mp   = rr;
  assign iss_slot = pick_slot[rr];
  assign fin_hit  = rel_hit[fin_mp];

  blk_kern_tbl #(.KERN_N(KERN_N), .BLK_W(BLK_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .load(kq_pop), .load_kidx(kq_kidx), .load_nblk(kq_nblk),
    .fin_hit(fin_hit), .fin_kidx(rel_kidx[fin_mp]), .fin_blk(rel_blk[fin_mp]),
    .busy(busy), .kdone_valid(kdone_valid), .kdone_kidx(kdone_kidx)
  );

  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> fit[iss_mp]);
  assert_pop_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kq_pop |-> !busy[kq_kidx]);

endmodule

// File: tb/blk_issue_top_tb.sv
`timescale 1ns/100ps
module blk_issue_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kq_valid = 1'b0;
  logic [1:0]  kq_kidx = '0;
  logic [15:0] kq_nblk = '0;
  logic [11:0] kq_thr = '0;
  logic [16:0] kq_reg = '0;
  logic [15:0] kq_smem = '0;
  logic        kq_pop, iss_valid, kdone_valid;
  logic [1:0]  iss_mp, iss_kidx, kdone_kidx;
  logic [3:0]  iss_slot;
  logic [15:0] iss_blk;
  logic        fin_valid = 1'b0;
  logic [1:0]  fin_mp = '0;
  logic [3:0]  fin_slot = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  blk_issue_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .kq_valid(kq_valid), .kq_kidx(kq_kidx), .kq_nblk(kq_nblk),
    .kq_thr(kq_thr), .kq_reg(kq_reg), .kq_smem(kq_smem),
    .kq_pop(kq_pop), .iss_valid(iss_valid), .iss_mp(iss_mp), .iss_slot(iss_slot),
    .iss_kidx(iss_kidx), .iss_blk(iss_blk),
    .fin_valid(fin_valid), .fin_mp(fin_mp), .fin_slot(fin_slot),
    .kdone_valid(kdone_valid), .kdone_kidx(kdone_kidx)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; kq_valid = 1'b0; fin_valid = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic put_kernel(input int kidx, input int nblk, input int thr, input int rg, input int sm);
    kq_valid = 1'b1;
    kq_kidx  = 2'(kidx);
    kq_nblk  = 16'(nblk);
    kq_thr   = 12'(thr);
    kq_reg   = 17'(rg);
    kq_smem  = 16'(sm);
  endtask

  task automatic fin(input int mp, input int slot);
    fin_valid = 1'b1;
    fin_mp    = 2'(mp);
    fin_slot  = 4'(slot);
  endtask

  task automatic exp_issue(input string req, input int mp, input int slot, input int kidx, input int blk);
    chk({req, " valid"}, int'(iss_valid), 1);
    chk({req, " mp"}, int'(iss_mp), mp);
    chk({req, " slot"}, int'(iss_slot), slot);
    chk({req, " kidx"}, int'(iss_kidx), kidx);
    chk({req, " blk"}, int'(iss_blk), blk);
  endtask

  task automatic exp_none(input string req);
    chk({req, " no issue"}, int'(iss_valid), 0);
  endtask

  // R1: idle state after reset
  task automatic t_reset();
    do_reset();
    tick(); settle();
    chk("R1 issue", int'(iss_valid), 0);
    chk("R1 pop", int'(kq_pop), 0);
    chk("R1 kdone", int'(kdone_valid), 0);
  endtask

  // R2, R3, R8: plain kernel of 6 blocks, then all finish
  task automatic t_basic();
    do_reset();
    tick(); put_kernel(3, 6, 64, 100, 256); settle();
    chk("R2 pop", int'(kq_pop), 1);
    for (int k = 1; k <= 6; k++) begin
      tick(); kq_valid = 1'b0; settle();
      exp_issue("R3", (k - 1) % 4, (k - 1) / 4, 3, k - 1);
    end
    tick(); settle(); exp_none("R2 after last");
    for (int j = 0; j < 6; j++) begin
      tick(); fin(j % 4, j / 4); settle();
      chk("R8 early", int'(kdone_valid), 0);
    end
    tick(); fin_valid = 1'b0; settle();
    chk("R8 done", int'(kdone_valid), 1);
    chk("R8 kidx", int'(kdone_kidx), 3);
    tick(); settle();
    chk("R8 one pulse", int'(kdone_valid), 0);
  endtask

  // R4: one resource kind allows a single block per multiprocessor
  task automatic t_gate(input string req, input int thr, input int rg, input int sm);
    do_reset();
    tick(); put_kernel(0, 6, thr, rg, sm); settle();
    for (int k = 1; k <= 4; k++) begin
      tick(); kq_valid = 1'b0; settle();
      exp_issue(req, k - 1, 0, 0, k - 1);
    end
    for (int k = 5; k <= 8; k++) begin
      tick(); settle(); exp_none(req);
    end
  endtask

  // R5: slot limit, lowest free slot used
  task automatic t_slots();
    do_reset();
    tick(); put_kernel(1, 66, 32, 1, 1); settle();
    for (int k = 1; k <= 64; k++) begin
      tick(); kq_valid = 1'b0; settle();
      exp_issue("R5 slot", (k - 1) % 4, (k - 1) / 4, 1, k - 1);
    end
    for (int k = 65; k <= 68; k++) begin
      tick(); settle(); exp_none("R5 slots full");
    end
  endtask

  // R5, R6, R10: thread cap, delayed release, empty-slot release ignored
  task automatic t_release();
    do_reset();
    tick(); put_kernel(2, 10, 1024, 1, 0); settle();
    for (int k = 1; k <= 8; k++) begin
      tick(); kq_valid = 1'b0; settle();
      exp_issue("R5 thr", (k - 1) % 4, (k - 1) / 4, 2, k - 1);
    end
    tick(); fin(1, 5); settle(); exp_none("R5 thr cap");
    tick(); fin_valid = 1'b0; settle(); exp_none("R5 thr cap");
    chk("R10 no kdone", int'(kdone_valid), 0);
    tick(); fin(2, 0); settle(); exp_none("R6 same cycle");
    tick(); fin_valid = 1'b0; settle(); exp_none("R6");
    tick(); settle(); exp_none("R6");
    tick(); settle(); exp_none("R10 mp1 still full");
    tick(); settle(); exp_issue("R6 reuse", 2, 0, 2, 8);
  endtask

  // R7, R8: next kernel taken after the last issue, mixing on one multiprocessor
  task automatic t_fallthru();
    do_reset();
    tick(); put_kernel(0, 2, 64, 10, 10); settle();
    chk("R2 pop A", int'(kq_pop), 1);
    tick(); put_kernel(1, 3, 64, 10, 10); settle();
    chk("R2 hold", int'(kq_pop), 0);
    exp_issue("R7 A0", 0, 0, 0, 0);
    tick(); settle();
    chk("R2 hold", int'(kq_pop), 0);
    exp_issue("R7 A1", 1, 0, 0, 1);
    tick(); settle();
    chk("R7 pop B", int'(kq_pop), 1);
    exp_none("R7 load cycle");
    tick(); kq_valid = 1'b0; settle(); exp_issue("R7 B0", 2, 0, 1, 0);
    tick(); settle(); exp_issue("R7 B1", 3, 0, 1, 1);
    tick(); settle(); exp_issue("R7 mixed", 0, 1, 1, 2);
    tick(); fin(2, 0); settle(); chk("R8 early", int'(kdone_valid), 0);
    tick(); fin(3, 0); settle(); chk("R8 early", int'(kdone_valid), 0);
    tick(); fin(0, 1); settle(); chk("R8 early", int'(kdone_valid), 0);
    tick(); fin(0, 0); settle();
    chk("R8 B done", int'(kdone_valid), 1);
    chk("R8 B kidx", int'(kdone_kidx), 1);
    tick(); fin(1, 0); settle(); chk("R8 gap", int'(kdone_valid), 0);
    tick(); fin_valid = 1'b0; settle();
    chk("R8 A done", int'(kdone_valid), 1);
    chk("R8 A kidx", int'(kdone_kidx), 0);
  endtask

  // R9: head with a busy index waits for that kernel's completion
  task automatic t_busy();
    do_reset();
    tick(); put_kernel(2, 1, 64, 10, 10); settle();
    chk("R9 first pop", int'(kq_pop), 1);
    tick(); settle();
    chk("R9 hold", int'(kq_pop), 0);
    exp_issue("R9 first", 0, 0, 2, 0);
    for (int k = 2; k <= 4; k++) begin
      tick(); settle(); chk("R9 busy hold", int'(kq_pop), 0);
    end
    tick(); fin(0, 0); settle(); chk("R9 busy at fin", int'(kq_pop), 0);
    tick(); fin_valid = 1'b0; settle();
    chk("R9 pop on done", int'(kq_pop), 1);
    chk("R8 kdone", int'(kdone_valid), 1);
    chk("R8 kidx", int'(kdone_kidx), 2);
    tick(); kq_valid = 1'b0; settle();
    exp_issue("R9 second", 1, 0, 2, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_gate("R4 regs", 32, 40000, 0);
    t_gate("R4 smem", 32, 1, 30000);
    t_gate("R4 threads", 1500, 1, 0);
    t_slots();
    t_release();
    t_fallthru();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule